// File: doc/BRIEF.md
# Processor Clock-State Power Controller

This block follows a processor core through its low-power clock states. It watches a halt request, an active-low stop request, an active-low deep-idle request, a bus-clock-good flag, a snoop request and a management interrupt. From these it steps between six states: run, halted, stopped, snoop-service, deep idle and management handler. Its outputs are the state code, a core clock enable, a one-cycle strobe that marks the halt bus cycle, a snoop acknowledge and a ready flag.

Wake-up latency is modelled by one down-counter. A parameter sets its length in core-clock cycles. While the counter is non-zero the ready flag stays low, the block makes no state move out of run, stopped or handler, and it acknowledges no snoop. Only the core clock enable is ever dropped, and the block has no control over the bus clock. The controller is placed next to the core's clock gate and bus unit, which act on its outputs.

The state code is 0 for run, 1 for halted, 2 for stopped, 3 for snoop-service, 4 for deep idle and 5 for handler.

Top module: `clk_state_ctrl`

## Requirements
- R1: While rst_ni is low the block is in run (code 0). Core clock enable and ready are high, and the halt strobe and snoop acknowledge are low.
- R2: In run with no wake count pending, a high halt_req_i moves the block to halted (code 1) at the next edge. halt_cyc_o is high for exactly that first halted cycle. The core clock enable stays high in run, halted and handler.
- R3: In halted, a low stop_req_ni moves the block to stopped (code 2) with the core clock enable low. Releasing the stop request then returns the block to halted, and halt_cyc_o stays low.
- R4: If stopped was entered from run, releasing the stop request returns the block to run. Ready is then low for exactly WAKE_CYC cycles after the state reads 0.
- R5: In halted, a low halt_req_i returns the block to run. Ready is low for WAKE_CYC cycles and then rises.
- R6: While a wake count is pending, the block makes no state change out of run, stopped or handler, and snoop_ack_o stays low.
- R7: A high mgmt_irq_i in halted enters the handler (code 5) and loads the wake count. The handler lasts while mgmt_irq_i is high. When it falls, the block goes to halted if mgmt_ret_halt_i is high and to run if it is low. Neither return produces a halt strobe or a new wake count.
- R8: A high snoop_req_i in halted or stopped moves the block to snoop-service (code 3) at the next edge with the core clock enable low. It returns to the state it came from once snoop_req_i is low. snoop_ack_o is high one cycle after each cycle with snoop_req_i high, except in deep idle or while a count is pending. In run, a snoop leaves the state unchanged.
- R9: In stopped, a low deep_req_ni or a low bus_clk_ok_i moves the block to deep idle (code 4). Snoops are not acknowledged there.
- R10: Deep idle returns to stopped once deep_req_ni and bus_clk_ok_i are both high. The block then stays in stopped for WAKE_CYC cycles before it honours any further request.
- R11: Priorities: in stopped, deep-idle entry wins over a snoop, and a snoop wins over a stop release. In halted, the interrupt wins over a snoop, a snoop wins over the stop request, and the stop request wins over a wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_req_i | input | 1 | Halt request, level |
| stop_req_ni | input | 1 | Stop request, active low |
| deep_req_ni | input | 1 | Deep-idle request, active low |
| bus_clk_ok_i | input | 1 | Bus clock running |
| snoop_req_i | input | 1 | Snoop request, level |
| mgmt_irq_i | input | 1 | Management interrupt, held for the duration of the handler |
| mgmt_ret_halt_i | input | 1 | Handler return target: 1 halted, 0 run |
| state_o | output | 3 | Current state code |
| core_clk_en_o | output | 1 | Core clock enable |
| halt_cyc_o | output | 1 | One-cycle halt bus-cycle strobe |
| snoop_ack_o | output | 1 | Snoop acknowledge |
| ready_o | output | 1 | Core awake and wake count expired |

## Verification
The bench uses a wake count of five cycles. It goes after the return from stopped to halted: a design that dropped the origin of the stopped state would go back to run, or would issue a second halt strobe. It measures the ready edge to the cycle after each wake path, which exposes an off-by-one in the counter or a count loaded on the wrong transition. It applies simultaneous requests to check each priority order, and it raises requests during a pending count. A design without the count gate would leave run or stopped early, or would acknowledge a snoop while the core is still waking.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_QUIET = 3'd2,
    ST_SNOOP = 3'd3,
    ST_DEEP  = 3'd4,
    ST_SMM   = 3'd5
  } pwr_st_e;
endpackage

// File: rtl/pcs_wake_timer.sv
module pcs_wake_timer #(
  parameter int WAKE_CYC = 1330
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= CW'(WAKE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);

  // R4: a pending count falls by one per cycle until reloaded
  a_r4_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  // R10: a load always leaves a full count behind
  a_r10_load_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == CW'(WAKE_CYC)));
endmodule

// File: rtl/pcs_next_state.sv
module pcs_next_state
  import pcs_pkg::*;
(
  input  pwr_st_e cur_i,
  input  logic    busy_i,
  input  logic    halt_req_i,
  input  logic    stop_req_ni,
  input  logic    deep_req_ni,
  input  logic    bus_clk_ok_i,
  input  logic    snoop_req_i,
  input  logic    mgmt_irq_i,
  input  logic    mgmt_ret_halt_i,
  input  logic    from_halt_i,
  input  logic    snp_quiet_i,
  output pwr_st_e nxt_o,
  output logic    load_o,
  output logic    from_halt_d_o,
  output logic    snp_quiet_d_o
);
  always_comb begin
    nxt_o         = cur_i;
    load_o        = 1'b0;
    from_halt_d_o = from_halt_i;
    snp_quiet_d_o = snp_quiet_i;
    case (cur_i)
      ST_RUN: begin
        if (!busy_i) begin
          if (mgmt_irq_i) nxt_o = ST_SMM;
          else if (!stop_req_ni) begin
            nxt_o         = ST_QUIET;
            from_halt_d_o = 1'b0;
          end else if (halt_req_i) nxt_o = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (mgmt_irq_i) begin
          nxt_o  = ST_SMM;
          load_o = 1'b1;
        end else if (snoop_req_i) begin
          nxt_o         = ST_SNOOP;
          snp_quiet_d_o = 1'b0;
        end else if (!stop_req_ni) begin
          nxt_o         = ST_QUIET;
          from_halt_d_o = 1'b1;
        end else if (!halt_req_i) begin
          nxt_o  = ST_RUN;
          load_o = 1'b1;
        end
      end
      ST_QUIET: begin
        if (!busy_i) begin
          if (!deep_req_ni || !bus_clk_ok_i) nxt_o = ST_DEEP;
          else if (snoop_req_i) begin
            nxt_o         = ST_SNOOP;
            snp_quiet_d_o = 1'b1;
          end else if (stop_req_ni) begin
            if (from_halt_i) nxt_o = ST_IDLE;
            else begin
              nxt_o  = ST_RUN;
              load_o = 1'b1;
            end
          end
        end
      end
      ST_SNOOP: begin
        if (!snoop_req_i) nxt_o = snp_quiet_i ? ST_QUIET : ST_IDLE;
      end
      ST_DEEP: begin
        if (deep_req_ni && bus_clk_ok_i) begin
          nxt_o  = ST_QUIET;
          load_o = 1'b1;
        end
      end
      ST_SMM: begin
        if (!busy_i && !mgmt_irq_i) nxt_o = mgmt_ret_halt_i ? ST_IDLE : ST_RUN;
      end
      default: nxt_o = ST_RUN;
    endcase
  end
endmodule

// File: rtl/clk_state_ctrl.sv
module clk_state_ctrl
  import pcs_pkg::*;
#(
  parameter int WAKE_CYC = 1330
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_req_i,
  input  logic       stop_req_ni,
  input  logic       deep_req_ni,
  input  logic       bus_clk_ok_i,
  input  logic       snoop_req_i,
  input  logic       mgmt_irq_i,
  input  logic       mgmt_ret_halt_i,
  output logic [2:0] state_o,
  output logic       core_clk_en_o,
  output logic       halt_cyc_o,
  output logic       snoop_ack_o,
  output logic       ready_o
);
  pwr_st_e state_q, state_d;
  logic    busy, load;
  logic    from_halt_q, from_halt_d;
  logic    snp_quiet_q, snp_quiet_d;
  logic    strobe_q, ack_q;

  pcs_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .busy_o (busy)
  );

  pcs_next_state u_nxt (
    .cur_i           (state_q),
    .busy_i          (busy),
    .halt_req_i      (halt_req_i),
    .stop_req_ni     (stop_req_ni),
    .deep_req_ni     (deep_req_ni),
    .bus_clk_ok_i    (bus_clk_ok_i),
    .snoop_req_i     (snoop_req_i),
    .mgmt_irq_i      (mgmt_irq_i),
    .mgmt_ret_halt_i (mgmt_ret_halt_i),
    .from_halt_i     (from_halt_q),
    .snp_quiet_i     (snp_quiet_q),
    .nxt_o           (state_d),
    .load_o          (load),
    .from_halt_d_o   (from_halt_d),
    .snp_quiet_d_o   (snp_quiet_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      from_halt_q <= 1'b0;
      snp_quiet_q <= 1'b0;
      strobe_q    <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q     <= state_d;
      from_halt_q <= from_halt_d;
      snp_quiet_q <= snp_quiet_d;
      // halt bus cycle only on a fresh halt from run
      strobe_q    <= (state_q == ST_RUN) && (state_d == ST_IDLE);
      ack_q       <= snoop_req_i && !busy && (state_q != ST_DEEP);
    end
  end

  assign state_o       = state_q;
  assign core_clk_en_o = (state_q == ST_RUN) || (state_q == ST_IDLE) || (state_q == ST_SMM);
  assign ready_o       = ((state_q == ST_RUN) || (state_q == ST_SMM)) && !busy;
  assign halt_cyc_o    = strobe_q;
  assign snoop_ack_o   = ack_q;

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |=> !halt_cyc_o);

  a_r2_strobe_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |-> (state_q == ST_IDLE && $past(state_q) == ST_RUN));

  a_r3_no_strobe_reentry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q) != ST_RUN) |-> !halt_cyc_o);

  a_r6_hold_while_waking: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && state_q != ST_DEEP) |=> (state_q == $past(state_q)));

  a_r9_deep_from_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEEP && $past(state_q) != ST_DEEP) |-> ($past(state_q) == ST_QUIET));

  a_r9_no_ack_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_DEEP) |-> !snoop_ack_o);
endmodule

// File: tb/clk_state_ctrl_bench.sv
module clk_state_ctrl_bench;
  localparam int W = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic halt_req_i = 1'b0, stop_req_ni = 1'b1, deep_req_ni = 1'b1, bus_clk_ok_i = 1'b1;
  logic snoop_req_i = 1'b0, mgmt_irq_i = 1'b0, mgmt_ret_halt_i = 1'b0;
  logic [2:0] state_o;
  logic core_clk_en_o, halt_cyc_o, snoop_ack_o, ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  clk_state_ctrl #(.WAKE_CYC(W)) u_clk_state_ctrl (
    .clk_i, .rst_ni, .halt_req_i, .stop_req_ni, .deep_req_ni, .bus_clk_ok_i,
    .snoop_req_i, .mgmt_irq_i, .mgmt_ret_halt_i,
    .state_o, .core_clk_en_o, .halt_cyc_o, .snoop_ack_o, .ready_o
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    chk("R1", "state", state_o, 0);
    chk("R1", "clk_en", core_clk_en_o, 1);
    chk("R1", "ready", ready_o, 1);
    chk("R1", "strobe", halt_cyc_o, 0);
    chk("R1", "ack", snoop_ack_o, 0);

    // R2 halt entry
    halt_req_i = 1; tick(1);
    chk("R2", "state", state_o, 1);
    chk("R2", "strobe", halt_cyc_o, 1);
    chk("R2", "clk_en", core_clk_en_o, 1);
    tick(1);
    chk("R2", "strobe2", halt_cyc_o, 0);

    // R3 halted -> stopped -> halted
    stop_req_ni = 0; tick(1);
    chk("R3", "state", state_o, 2);
    chk("R3", "clk_en", core_clk_en_o, 0);
    stop_req_ni = 1; tick(1);
    chk("R3", "back", state_o, 1);
    chk("R3", "strobe", halt_cyc_o, 0);
    tick(1);
    chk("R3", "strobe2", halt_cyc_o, 0);

    // R5 wake from halted
    halt_req_i = 0; tick(1);
    chk("R5", "state", state_o, 0);
    chk("R5", "ready0", ready_o, 0);
    tick(W - 1);
    chk("R5", "ready_late", ready_o, 0);
    tick(1);
    chk("R5", "ready1", ready_o, 1);

    // R6 requests during pending count
    halt_req_i = 1; tick(1);
    halt_req_i = 0; tick(1);
    chk("R6", "entry", state_o, 0);
    halt_req_i = 1; snoop_req_i = 1; tick(1);
    chk("R6", "hold", state_o, 0);
    chk("R6", "no_ack", snoop_ack_o, 0);
    halt_req_i = 0; snoop_req_i = 0; tick(W - 1);
    chk("R6", "ready", ready_o, 1);
    chk("R6", "state", state_o, 0);

    // R4 stopped from run
    stop_req_ni = 0; tick(1);
    chk("R4", "state", state_o, 2);
    chk("R4", "ready", ready_o, 0);
    stop_req_ni = 1; tick(1);
    chk("R4", "back", state_o, 0);
    chk("R4", "ready0", ready_o, 0);
    tick(W - 1);
    chk("R4", "ready_late", ready_o, 0);
    tick(1);
    chk("R4", "ready1", ready_o, 1);

    // R11 stopped priority, R9 deep entry
    stop_req_ni = 0; tick(1);
    deep_req_ni = 0; snoop_req_i = 1; stop_req_ni = 1; tick(1);
    chk("R11", "deep_first", state_o, 4);
    tick(1);
    chk("R9", "state", state_o, 4);
    chk("R9", "no_ack", snoop_ack_o, 0);
    snoop_req_i = 0;

    // R10 deep exit wait
    deep_req_ni = 1; tick(1);
    chk("R10", "state", state_o, 2);
    tick(W - 1);
    chk("R10", "wait", state_o, 2);
    tick(1);
    chk("R10", "wait_end", state_o, 2);
    tick(1);
    chk("R10", "run", state_o, 0);
    chk("R10", "ready0", ready_o, 0);
    tick(W);
    chk("R10", "ready1", ready_o, 1);

    // R9 via bus clock loss
    stop_req_ni = 0; tick(1);
    bus_clk_ok_i = 0; tick(1);
    chk("R9", "bclk", state_o, 4);
    bus_clk_ok_i = 1; tick(1);
    chk("R10", "bclk_back", state_o, 2);
    tick(W);
    stop_req_ni = 1; tick(1);
    chk("R4", "run2", state_o, 0);
    tick(W);
    chk("R4", "ready2", ready_o, 1);

    // R8 snoops
    snoop_req_i = 1; tick(1);
    chk("R8", "run_state", state_o, 0);
    chk("R8", "run_ack", snoop_ack_o, 1);
    snoop_req_i = 0; tick(1);
    chk("R8", "ack_off", snoop_ack_o, 0);
    halt_req_i = 1; tick(1);
    snoop_req_i = 1; tick(1);
    chk("R8", "halt_snp", state_o, 3);
    chk("R8", "clk_en", core_clk_en_o, 0);
    chk("R8", "ack", snoop_ack_o, 1);
    snoop_req_i = 0; tick(1);
    chk("R8", "ret_halt", state_o, 1);
    chk("R8", "strobe", halt_cyc_o, 0);
    stop_req_ni = 0; tick(1);
    snoop_req_i = 1; tick(1);
    chk("R8", "quiet_snp", state_o, 3);
    tick(1);
    chk("R8", "hold_ack", snoop_ack_o, 1);
    snoop_req_i = 0; tick(1);
    chk("R8", "ret_quiet", state_o, 2);
    stop_req_ni = 1; tick(1);
    chk("R3", "ret_halt2", state_o, 1);
    chk("R3", "strobe3", halt_cyc_o, 0);

    // R11 halted priority, R7 handler
    mgmt_irq_i = 1; snoop_req_i = 1; stop_req_ni = 0; tick(1);
    chk("R11", "irq_first", state_o, 5);
    chk("R7", "ready0", ready_o, 0);
    chk("R7", "clk_en", core_clk_en_o, 1);
    snoop_req_i = 0; stop_req_ni = 1; mgmt_irq_i = 0; mgmt_ret_halt_i = 1; tick(1);
    chk("R7", "hold", state_o, 5);
    tick(W - 1);
    chk("R7", "ready1", ready_o, 1);
    chk("R7", "still", state_o, 5);
    tick(1);
    chk("R7", "to_halt", state_o, 1);
    chk("R7", "strobe", halt_cyc_o, 0);
    mgmt_irq_i = 1; tick(1);
    chk("R7", "again", state_o, 5);
    mgmt_irq_i = 0; mgmt_ret_halt_i = 0; halt_req_i = 0; tick(W);
    chk("R7", "ready2", ready_o, 1);
    tick(1);
    chk("R7", "to_run", state_o, 0);
    chk("R7", "run_ready", ready_o, 1);

    // R11 stop request beats wake in halted
    halt_req_i = 1; tick(1);
    halt_req_i = 0; stop_req_ni = 0; tick(1);
    chk("R11", "stop_first", state_o, 2);
    stop_req_ni = 1; tick(1);
    chk("R11", "to_halt", state_o, 1);
    tick(1);
    chk("R5", "wake", state_o, 0);
    chk("R5", "ready0", ready_o, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule